// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with One-of-Eight Demultiplexer

This block stores eight single-bit values and writes one of them at a time. A 3-bit select picks the target bit, and a single data bit is steered into it. Two active-low controls set the operating mode. With enable low and clear high, the selected bit follows the data input. Raising enable keeps the last value. With enable high and clear high, all bits hold. With enable high and clear low, every bit is cleared. With both controls low, the block acts as a one-of-eight demultiplexer: the selected bit carries the data and all others read zero.

The block sits in a single clock domain. The stored byte lives in a flip-flop register. The visible output is built combinationally from that register and the present inputs, so transparent and clearing modes show at the output in the same cycle, and no asynchronous latch is inferred. The register takes the visible value at each clock edge in every mode except hold.

The control decoder classifies each cycle into one of four named modes. MODE_WRITE is enable low with clear high. MODE_HOLD is enable high with clear high. MODE_CLEAR is enable high with clear low. MODE_DEMUX is both low. The mode changes freely from any mode to any other on the next cycle's inputs. A synchronous reset zeroes the stored byte. The select must only change while enable is high.

Top module: `addr_latch`

## Requirements
- R1: The select is binary coded with sel[2] as the most significant bit; sel=0 addresses q[0] and sel=7 addresses q[7].
- R2: In MODE_WRITE (en_n=0, clr_n=1), q[sel] equals din in the same cycle.
- R3: In MODE_WRITE, the seven unselected bits of q keep their stored values.
- R4: When en_n rises, the selected bit keeps the din value it had during the last clock cycle with en_n low.
- R5: In MODE_HOLD (en_n=1, clr_n=1), q keeps its value whatever din and sel do.
- R6: In MODE_CLEAR (en_n=1, clr_n=0), q is all zeros, and it stays zero after a return to MODE_HOLD.
- R7: In MODE_DEMUX (en_n=0, clr_n=0), q equals din shifted left by sel: at most one bit is set, and only at the selected position.
- R8: After a MODE_DEMUX cycle followed by MODE_HOLD, the stored byte is the demultiplexer pattern from the last demux cycle.
- R9: A synchronous active-high rst zeroes all eight stored bits; in MODE_HOLD after reset, q is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Data bit to be written |
| sel | input | 3 | Binary bit address, sel[2] most significant |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Visible latch contents |

## Verification
The bench sweeps every address with both data values through every mode. After each step it holds and reads the byte back.

One corner case is the capture at enable rise, where din flips together with en_n. A design that samples too late stores the new value instead of the old one.

The second is the demultiplexer. A design that forgets to zero the unselected bits leaks old contents there. A design that decodes the address backwards lights the mirrored position, which is exposed by an explicit check of the bit order.

A long random run keeps the address stable while enable is low. It catches a design in which hold mode lets din or sel disturb the outputs.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    // Operating mode derived from the two active-low controls.
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } lat_mode_e;

endpackage

// File: rtl/addr_latch_sel_dec.sv
module addr_latch_sel_dec #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [NBITS-1:0]  onehot
);

    // Binary select to one-hot strobe, one comparator per bit.
    for (genvar gi = 0; gi < NBITS; gi++) begin : g_dec
        assign onehot[gi] = (sel == ADDR_W'(gi));
    end

endmodule

// File: rtl/addr_latch_mode.sv
module addr_latch_mode
    import addr_latch_pkg::*;
(
    input  logic      en_n,
    input  logic      clr_n,
    output lat_mode_e mode
);

    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/addr_latch_view.sv
module addr_latch_view
    import addr_latch_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  lat_mode_e        mode,
    input  logic [NBITS-1:0] stored,
    input  logic [NBITS-1:0] onehot,
    input  logic             din,
    output logic [NBITS-1:0] view
);

    // Visible value: stored byte, with the addressed bit replaced or
    // the whole byte forced, depending on the mode of this cycle.
    always_comb begin
        unique case (mode)
            MODE_WRITE: view = (stored & ~onehot) | (onehot & {NBITS{din}});
            MODE_HOLD:  view = stored;
            MODE_DEMUX: view = onehot & {NBITS{din}};
            MODE_CLEAR: view = '0;
            default:    view = stored;
        endcase
    end

endmodule

// File: rtl/addr_latch.sv
module addr_latch
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      din,
    input  logic [ADDR_W-1:0]         sel,
    input  logic                      en_n,
    input  logic                      clr_n,
    output logic [(1 << ADDR_W)-1:0]  q
);

    localparam int NBITS = 1 << ADDR_W;

    lat_mode_e        mode;
    logic [NBITS-1:0] onehot;
    logic [NBITS-1:0] stored;
    logic [NBITS-1:0] view;

    addr_latch_sel_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel    (sel),
        .onehot (onehot)
    );

    addr_latch_mode u_mode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    addr_latch_view #(.NBITS(NBITS)) u_view (
        .mode   (mode),
        .stored (stored),
        .onehot (onehot),
        .din    (din),
        .view   (view)
    );

    // State register: takes the visible value in every mode but hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= '0;
        end else if (mode != MODE_HOLD) begin
            stored <= view;
        end
    end

    // Output process.
    always_comb begin
        q = view;
    end

    // Port-level checks.
    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr_n) |-> (q[sel] == din));                             // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (en_n && clr_n) ##1 (en_n && clr_n) |-> $stable(q));               // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_n && !clr_n) |-> (q == '0));                                   // R6
    AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr_n) |-> ($onehot0(q) && q[sel] == din));             // R7
    AST_RESET_ZERO: assert property (@(posedge clk)
        ($past(rst) && !rst && en_n && clr_n) |-> (q == '0));              // R9

endmodule

// File: tb/addr_latch_bench.sv
module addr_latch_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       din;
    logic [2:0] sel;
    logic       en_n;
    logic       clr_n;
    logic [7:0] q;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_store = 8'h00;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    addr_latch u_addr_latch (
        .clk (clk), .rst (rst), .din (din), .sel (sel),
        .en_n (en_n), .clr_n (clr_n), .q (q)
    );

    function automatic logic [7:0] model(input logic e, input logic c,
                                         input logic [2:0] s, input logic d,
                                         input logic [7:0] st);
        logic [7:0] m;
        m = 8'h01 << s;
        if (!e && c)       return (st & ~m) | (d ? m : 8'h00);
        else if (e && c)   return st;
        else if (!e && !c) return d ? m : 8'h00;
        else               return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check, then let the edge pass.
    task automatic step(input logic e, input logic c, input logic [2:0] s,
                        input logic d, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        en_n = e; clr_n = c; sel = s; din = d;
        #1;
        exp = model(e, c, s, d, m_store);
        check(tag, q, exp);
        @(posedge clk);
        if (!(e && c)) m_store = exp;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: q=%b expected completion", q);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] cur_sel;
        logic       prev_en;
        rst = 1'b1; din = 1'b1; sel = 3'd5; en_n = 1'b1; clr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_store = 8'h00;
        #1;
        check("R9 reset", q, 8'h00);

        // R1: bit order, computed arithmetically
        for (int s = 0; s < 8; s++) begin
            step(1'b1, 1'b0, 3'(s), 1'b0, "R6 clear");
            step(1'b1, 1'b1, 3'(s), 1'b1, "R5 hold");
            step(1'b0, 1'b1, 3'(s), 1'b1, "R2 write");
            step(1'b1, 1'b1, 3'(s), 1'b0, "R1 order");
            check("R1 order", q, 8'(1 << s));
        end

        // R2/R3/R4: write every address/data, flip din as enable rises
        step(1'b1, 1'b0, 3'd0, 1'b0, "R6 clear");
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                step(1'b1, 1'b1, 3'(s), 1'(d), "R5 hold");
                step(1'b0, 1'b1, 3'(s), 1'(~d), "R2 R3 write");
                step(1'b0, 1'b1, 3'(s), 1'(d), "R2 R3 write");
                step(1'b1, 1'b1, 3'(s), 1'(~d), "R4 capture");
                check("R4 bit", {7'd0, q[s]}, {7'd0, 1'(d)});
            end
        end

        // R7/R8: demultiplexer sweep over a full byte
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1, "R2 preload");
                step(1'b1, 1'b1, 3'(s), 1'b0, "R5 hold");
                step(1'b0, 1'b0, 3'(s), 1'(d), "R7 demux");
                step(1'b1, 1'b1, 3'(s), 1'(~d), "R8 after demux");
                check("R8 pattern", q, d ? 8'(1 << s) : 8'h00);
            end
        end

        // R6: clear a full byte, then hold
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1, "R2 preload");
        step(1'b1, 1'b0, 3'd3, 1'b1, "R6 clear");
        step(1'b1, 1'b1, 3'd3, 1'b1, "R6 after clear");
        check("R6 zero", q, 8'h00);

        // R5: hold with every din/sel combination
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 3'(2 * k), 1'b1, "R2 preload");
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 2; d++)
                step(1'b1, 1'b1, 3'(s), 1'(d), "R5 hold");
        check("R5 kept", q, 8'h55);

        // Random run: sel only changes while the previous en_n was high
        cur_sel = 3'd0;
        prev_en = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            logic e, c, d;
            e = 1'($urandom);
            c = ($urandom % 4) != 0;
            d = 1'($urandom);
            if (prev_en) cur_sel = 3'($urandom);
            step(e, c, cur_sel, d, "R2 R3 R5 R6 R7 random");
            prev_en = e;
        end

        // R9: reset mid-run clears stored bits
        step(1'b0, 1'b1, 3'd6, 1'b1, "R2 write");
        @(negedge clk);
        rst = 1'b1; en_n = 1'b1; clr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_store = 8'h00;
        #1;
        check("R9 reset", q, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule